// File: doc/BRIEF.md
# Shared-Bus Accumulator Datapath

This block is the datapath of a small accumulator machine. Every transfer between its storage elements travels over one 8-bit internal bus. The storage elements are an accumulator, a second operand register, an instruction register, a 4-bit address register, a 16-entry by 8-bit memory, a 4-bit program counter and a display register. An adder/subtractor takes its operands from the accumulator and the operand register. The bus carries the value of whichever source has its drive strobe raised, and it reads zero when no drive strobe is raised. Each register samples the bus on the rising clock edge when its load strobe is high.

An external sequencer owns the 16-bit control word. Here the bench plays that role and drives the word directly. A program-loading port writes the memory so that programs can be placed before a run. A stop strobe freezes all state until the next reset.

Top module: `busdp_core`

## Requirements
- R1: While rst_n is low, and after it is released, the accumulator, operand register, instruction register, address register, program counter and display register all read zero, and halted_o is 0. Memory contents are not cleared by reset.
- R2: Control word bits are drive strobes: bit0 accumulator, bit2 operand register, bit4 instruction register, bit7 memory, bit9 ALU, bit11 program counter. At most one of them is high at a time. The bus equals the value of the selected source, and it is 0 when none of them is high.
- R3: When the instruction register drives (bit4), the bus carries its low nibble in bits 3:0 and zero in bits 7:4. ir_o always shows all 8 bits of the instruction register.
- R4: When the ALU drives (bit9), the bus carries (A + B) mod 256 if bit10 is 0, and (A - B) mod 256 if bit10 is 1.
- R5: The program counter loads bus bits 3:0 when bit12 is high. It increments by one, wrapping from 15 to 0, when bit13 is high. When both are high, the load wins. When it drives, the bus upper nibble is zero.
- R6: The address register loads bus bits 3:0 when bit6 is high. Its value selects the memory word that the memory drives (bit7) and the word that is written with the bus value when bit8 is high. A read in the same cycle as a write returns the old word.
- R7: Load strobes are bit1 accumulator, bit3 operand register, bit5 instruction register, bit6 address register, bit8 memory write and bit14 display register. All of them take effect at the same rising edge, all from the same bus value. disp_o shows the display register.
- R8: When bit15 (stop) is high at a rising edge, halted_o becomes 1 at that edge. No register or memory write takes effect at that edge, and none takes effect at any later edge until reset.
- R9: When prog_we is high at a rising edge, memory word prog_addr takes prog_data. This happens independently of the control word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, all state updates on the rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_i | input | 16 | Control word of drive and load strobes |
| prog_we | input | 1 | Program-loading write enable |
| prog_addr | input | 4 | Program-loading memory address |
| prog_data | input | 8 | Program-loading write data |
| ir_o | output | 8 | Instruction register contents |
| disp_o | output | 8 | Display register contents |
| halted_o | output | 1 | Stop has been taken since reset |

## Verification
A program-counter load and a program-counter increment can be requested in the same cycle. So can a memory read and a memory write to the word the address register selects. The bench issues both pairs as directed control words and also produces them through random load masks. It then reads the counter and the memory back through the display register. Each result is judged against a bench model in which the load beats the increment and the read returns the word held before the edge.

// File: rtl/busdp_pkg.sv
package busdp_pkg;
  localparam int CTL_W     = 16;
  localparam int DATA_W    = 8;
  localparam int ADDR_W    = 4;

  // control word bit positions
  localparam int C_ACC_DRV = 0;
  localparam int C_ACC_LD  = 1;
  localparam int C_OPB_DRV = 2;
  localparam int C_OPB_LD  = 3;
  localparam int C_IR_DRV  = 4;
  localparam int C_IR_LD   = 5;
  localparam int C_ADR_LD  = 6;
  localparam int C_MEM_DRV = 7;
  localparam int C_MEM_WR  = 8;
  localparam int C_ALU_DRV = 9;
  localparam int C_ALU_SUB = 10;
  localparam int C_PC_DRV  = 11;
  localparam int C_PC_LD   = 12;
  localparam int C_PC_STEP = 13;
  localparam int C_DSP_LD  = 14;
  localparam int C_STOP    = 15;

  // bus source slots
  localparam int S_ACC  = 0;
  localparam int S_OPB  = 1;
  localparam int S_IR   = 2;
  localparam int S_MEM  = 3;
  localparam int S_ALU  = 4;
  localparam int S_PC   = 5;
  localparam int N_SRC  = 6;

  function automatic logic [DATA_W-1:0] alu_calc(input logic [DATA_W-1:0] a,
                                                 input logic [DATA_W-1:0] b,
                                                 input logic              sub);
    return sub ? (a - b) : (a + b);
  endfunction

  function automatic logic [DATA_W-1:0] nib_ext(input logic [ADDR_W-1:0] v);
    return {{(DATA_W-ADDR_W){1'b0}}, v};
  endfunction
endpackage

// File: rtl/dp_reg.sv
module dp_reg #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         en,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/dp_pc.sv
module dp_pc #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hold,
  input  logic         load,
  input  logic         step,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] q_next;
  logic         at_top;

  assign at_top = (q == {W{1'b1}});

  always_comb begin
    q_next = q;
    if (load)      q_next = d;
    else if (step) q_next = q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (!hold) q <= q_next;
  end

  // R5
  pc_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load && !hold && at_top) |=> (q == '0));
  // R5
  pc_load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !hold) |=> (q == $past(d)));
  // R8
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hold |=> $stable(q));
endmodule

// File: rtl/dp_ram.sv
module dp_ram #(
  parameter int AW = 4,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  input  logic          init_we,
  input  logic [AW-1:0] init_addr,
  input  logic [DW-1:0] init_data
);
  localparam int DEPTH = 1 << AW;
  logic [DW-1:0] mem [DEPTH];

  assign rdata = mem[addr];

  always_ff @(posedge clk) begin
    if (we)      mem[addr]      <= wdata;
    if (init_we) mem[init_addr] <= init_data;
  end
endmodule

// File: rtl/dp_bus.sv
module dp_bus #(
  parameter int N  = 6,
  parameter int DW = 8
) (
  input  logic [N-1:0]         sel,
  input  logic [N-1:0][DW-1:0] src,
  output logic [DW-1:0]        bus
);
  logic [N-1:0][DW-1:0] gated;
  genvar gi;
  generate
    for (gi = 0; gi < N; gi++) begin : g_gate
      assign gated[gi] = sel[gi] ? src[gi] : '0;
    end
  endgenerate

  always_comb begin
    bus = '0;
    for (int i = 0; i < N; i++) bus = bus | gated[i];
  end
endmodule

// File: rtl/busdp_core.sv
module busdp_core
  import busdp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CTL_W-1:0]  ctl_i,
  input  logic              prog_we,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [DATA_W-1:0] prog_data,
  output logic [DATA_W-1:0] ir_o,
  output logic [DATA_W-1:0] disp_o,
  output logic              halted_o
);
  logic [DATA_W-1:0] acc_q, opb_q, ir_q, dsp_q, mem_rd, alu_y, bus;
  logic [ADDR_W-1:0] adr_q, pc_q;
  logic              halted_q;
  logic              freeze, upd;
  logic [N_SRC-1:0]             drv;
  logic [N_SRC-1:0][DATA_W-1:0] srcs;

  // visible events for the checks
  logic ev_acc_ld, ev_opb_ld, ev_ir_ld, ev_adr_ld, ev_dsp_ld, ev_mem_wr;

  assign freeze    = halted_q | ctl_i[C_STOP];
  assign upd       = ~freeze;
  assign ev_acc_ld = upd & ctl_i[C_ACC_LD];
  assign ev_opb_ld = upd & ctl_i[C_OPB_LD];
  assign ev_ir_ld  = upd & ctl_i[C_IR_LD];
  assign ev_adr_ld = upd & ctl_i[C_ADR_LD];
  assign ev_dsp_ld = upd & ctl_i[C_DSP_LD];
  assign ev_mem_wr = upd & ctl_i[C_MEM_WR];

  assign drv[S_ACC] = ctl_i[C_ACC_DRV];
  assign drv[S_OPB] = ctl_i[C_OPB_DRV];
  assign drv[S_IR]  = ctl_i[C_IR_DRV];
  assign drv[S_MEM] = ctl_i[C_MEM_DRV];
  assign drv[S_ALU] = ctl_i[C_ALU_DRV];
  assign drv[S_PC]  = ctl_i[C_PC_DRV];

  assign alu_y      = alu_calc(acc_q, opb_q, ctl_i[C_ALU_SUB]);

  assign srcs[S_ACC] = acc_q;
  assign srcs[S_OPB] = opb_q;
  assign srcs[S_IR]  = nib_ext(ir_q[ADDR_W-1:0]);
  assign srcs[S_MEM] = mem_rd;
  assign srcs[S_ALU] = alu_y;
  assign srcs[S_PC]  = nib_ext(pc_q);

  dp_bus #(.N(N_SRC), .DW(DATA_W)) u_bus (.sel(drv), .src(srcs), .bus(bus));

  dp_reg #(.W(DATA_W)) u_acc (.clk(clk), .rst_n(rst_n), .en(ev_acc_ld), .d(bus), .q(acc_q));
  dp_reg #(.W(DATA_W)) u_opb (.clk(clk), .rst_n(rst_n), .en(ev_opb_ld), .d(bus), .q(opb_q));
  dp_reg #(.W(DATA_W)) u_ir  (.clk(clk), .rst_n(rst_n), .en(ev_ir_ld),  .d(bus), .q(ir_q));
  dp_reg #(.W(DATA_W)) u_dsp (.clk(clk), .rst_n(rst_n), .en(ev_dsp_ld), .d(bus), .q(dsp_q));
  dp_reg #(.W(ADDR_W)) u_adr (.clk(clk), .rst_n(rst_n), .en(ev_adr_ld),
                              .d(bus[ADDR_W-1:0]), .q(adr_q));

  dp_pc #(.W(ADDR_W)) u_pc (
    .clk(clk), .rst_n(rst_n), .hold(freeze),
    .load(ctl_i[C_PC_LD]), .step(ctl_i[C_PC_STEP]),
    .d(bus[ADDR_W-1:0]), .q(pc_q)
  );

  dp_ram #(.AW(ADDR_W), .DW(DATA_W)) u_ram (
    .clk(clk), .we(ev_mem_wr), .addr(adr_q), .wdata(bus), .rdata(mem_rd),
    .init_we(prog_we), .init_addr(prog_addr), .init_data(prog_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              halted_q <= 1'b0;
    else if (ctl_i[C_STOP])  halted_q <= 1'b1;
  end

  assign ir_o     = ir_q;
  assign disp_o   = dsp_q;
  assign halted_o = halted_q;

  // R2
  drive_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(drv));
  // R2
  idle_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dsp_ld && drv == '0) |=> (disp_o == '0));
  // R3
  ir_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_dsp_ld && drv[S_IR]) |=> (disp_o[DATA_W-1:ADDR_W] == '0));
  // R8
  halt_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    halted_o |=> halted_o);
  // R8
  halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_i[C_STOP] || halted_o) |=> ($stable(disp_o) && $stable(ir_o) && halted_o));
endmodule

// File: tb/test_busdp_core.sv
module test_busdp_core;
  localparam int PERIOD = 10;

  localparam logic [15:0] K_ACC_DRV = 16'h0001, K_ACC_LD = 16'h0002,
                          K_OPB_DRV = 16'h0004, K_OPB_LD = 16'h0008,
                          K_IR_DRV  = 16'h0010, K_IR_LD  = 16'h0020,
                          K_ADR_LD  = 16'h0040, K_MEM_DRV = 16'h0080,
                          K_MEM_WR  = 16'h0100, K_ALU_DRV = 16'h0200,
                          K_ALU_SUB = 16'h0400, K_PC_DRV = 16'h0800,
                          K_PC_LD   = 16'h1000, K_PC_STEP = 16'h2000,
                          K_DSP_LD  = 16'h4000, K_STOP   = 16'h8000;

  logic        clk = 0, rst_n = 0, prog_we = 0;
  logic [15:0] ctl = '0;
  logic [3:0]  prog_addr = '0;
  logic [7:0]  prog_data = '0;
  logic [7:0]  ir_o, disp_o;
  logic        halted_o;

  int checks = 0, fails = 0;
  bit done = 0;

  // bench model
  logic [7:0] m_a, m_b, m_ir, m_out;
  logic [3:0] m_adr, m_pc;
  logic       m_halt;
  logic [7:0] m_mem [16];

  always #(PERIOD/2) clk = ~clk;

  busdp_core i_busdp_core (
    .clk(clk), .rst_n(rst_n), .ctl_i(ctl), .prog_we(prog_we),
    .prog_addr(prog_addr), .prog_data(prog_data),
    .ir_o(ir_o), .disp_o(disp_o), .halted_o(halted_o)
  );

  function automatic logic [7:0] exp_alu(input logic [7:0] a, input logic [7:0] b,
                                         input bit sub);
    int t;
    t = sub ? (int'(a) + 256 - int'(b)) : (int'(a) + int'(b));
    return 8'(t % 256);
  endfunction

  task automatic check(input string tag);
    checks++;
    if (ir_o !== m_ir || disp_o !== m_out || halted_o !== m_halt) begin
      fails++;
      $display("FAIL %s: ir=%h disp=%h halted=%b expected ir=%h disp=%h halted=%b",
               tag, ir_o, disp_o, halted_o, m_ir, m_out, m_halt);
    end
  endtask

  task automatic model_reset();
    m_a = 0; m_b = 0; m_ir = 0; m_out = 0; m_adr = 0; m_pc = 0; m_halt = 0;
  endtask

  // called at a negedge: drive, model the edge, check at next negedge
  task automatic cyc(input logic [15:0] c, input string tag);
    logic [7:0] bus;
    ctl = c;
    bus = 8'h00;
    if (c & K_ACC_DRV) bus = m_a;
    if (c & K_OPB_DRV) bus = m_b;
    if (c & K_IR_DRV)  bus = {4'h0, m_ir[3:0]};
    if (c & K_MEM_DRV) bus = m_mem[m_adr];
    if (c & K_ALU_DRV) bus = exp_alu(m_a, m_b, (c & K_ALU_SUB) != 0);
    if (c & K_PC_DRV)  bus = {4'h0, m_pc};
    @(posedge clk);
    if (!m_halt && !(c & K_STOP)) begin
      if (c & K_MEM_WR) m_mem[m_adr] = bus;
      if (c & K_ACC_LD) m_a = bus;
      if (c & K_OPB_LD) m_b = bus;
      if (c & K_IR_LD)  m_ir = bus;
      if (c & K_DSP_LD) m_out = bus;
      if (c & K_ADR_LD) m_adr = bus[3:0];
      if (c & K_PC_LD)  m_pc = bus[3:0];
      else if (c & K_PC_STEP) m_pc = m_pc + 4'd1;
    end
    if (c & K_STOP) m_halt = 1;
    @(negedge clk);
    check(tag);
  endtask

  task automatic prog(input logic [3:0] a, input logic [7:0] d);
    prog_we = 1; prog_addr = a; prog_data = d;
    @(posedge clk);
    m_mem[a] = d;
    @(negedge clk);
    prog_we = 0;
  endtask

  task automatic do_reset();
    rst_n = 0; ctl = '0;
    @(negedge clk); @(negedge clk);
    model_reset();
    check("R1 in reset");
    rst_n = 1;
    @(negedge clk);
    check("R1 after release");
  endtask

  initial begin
    #(PERIOD * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: run did not finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] c;
    int r;
    void'($urandom(32'd20240611));
    model_reset();
    for (int i = 0; i < 16; i++) m_mem[i] = 8'h00;
    do_reset();
    cyc(K_PC_DRV | K_DSP_LD, "R1 pc zero");
    cyc(K_ACC_DRV | K_DSP_LD, "R1 acc zero");
    for (int i = 0; i < 16; i++) prog(4'(i), 8'h00);
    prog(4'd0, 8'h37);
    prog(4'd7, 8'hC8);
    prog(4'd8, 8'h5A);
    prog(4'd9, 8'h5F);
    cyc(K_MEM_DRV | K_IR_LD, "R9 ir from mem0");
    cyc(K_IR_DRV | K_DSP_LD, "R3 ir low nibble");
    cyc(K_IR_DRV | K_ADR_LD, "R6 adr from ir");
    cyc(K_MEM_DRV | K_DSP_LD, "R6 read mem7");
    cyc(K_DSP_LD, "R2 idle bus zero");
    cyc(K_MEM_DRV | K_ACC_LD, "R4 load acc");
    cyc(K_IR_DRV | K_PC_LD, "R5 pc load");
    cyc(K_PC_STEP, "R5 pc step");
    cyc(K_PC_DRV | K_ADR_LD, "R5 pc drive");
    cyc(K_MEM_DRV | K_OPB_LD, "R4 load opb");
    cyc(K_ALU_DRV | K_DSP_LD, "R4 add wraps");
    cyc(K_ALU_DRV | K_ALU_SUB | K_DSP_LD, "R4 subtract");
    cyc(K_OPB_DRV | K_ACC_LD, "R2 opb to acc");
    cyc(K_ALU_DRV | K_ALU_SUB | K_DSP_LD, "R4 subtract to zero");
    cyc(K_PC_STEP, "R5 step");
    cyc(K_PC_DRV | K_ADR_LD, "R6 adr 9");
    cyc(K_MEM_DRV | K_PC_LD, "R5 pc load F");
    cyc(K_PC_STEP, "R5 wrap");
    cyc(K_PC_DRV | K_DSP_LD, "R5 wrap seen");
    cyc(K_MEM_DRV | K_PC_LD | K_PC_STEP, "R5 load beats step");
    cyc(K_PC_DRV | K_DSP_LD, "R5 load beats step seen");
    cyc(K_ACC_DRV | K_MEM_WR | K_DSP_LD, "R6 write");
    cyc(K_MEM_DRV | K_DSP_LD, "R6 write readback");
    cyc(K_ALU_DRV | K_MEM_WR, "R6 write alu");
    cyc(K_MEM_DRV | K_MEM_WR | K_DSP_LD, "R6 read old on write");
    cyc(K_MEM_DRV | K_ACC_LD | K_OPB_LD | K_DSP_LD | K_IR_LD, "R7 multi load");
    cyc(K_OPB_DRV | K_DSP_LD, "R7 opb shared value");
    for (int i = 0; i < 16; i++) prog(4'(i), 8'($urandom));
    for (int n = 0; n < 600; n++) begin
      r = $urandom % 8;
      c = 16'h0;
      case (r)
        1: c = K_ACC_DRV; 2: c = K_OPB_DRV; 3: c = K_IR_DRV;
        4: c = K_MEM_DRV; 5: c = K_ALU_DRV; 6: c = K_PC_DRV;
        default: c = 16'h0;
      endcase
      c = c | (16'($urandom) & (K_ACC_LD | K_OPB_LD | K_IR_LD | K_ADR_LD | K_MEM_WR |
                                K_ALU_SUB | K_PC_LD | K_PC_STEP | K_DSP_LD));
      cyc(c, "R7 random");
    end
    cyc(K_ACC_DRV | K_DSP_LD, "R8 before stop");
    cyc(K_STOP | K_PC_DRV | K_DSP_LD | K_IR_LD | K_MEM_WR, "R8 stop edge");
    for (int n = 0; n < 20; n++)
      cyc(K_MEM_DRV | K_DSP_LD | K_IR_LD | K_ACC_LD | K_ADR_LD | K_MEM_WR | K_PC_STEP,
          "R8 frozen");
    do_reset();
    cyc(K_MEM_DRV | K_DSP_LD, "R1 memory kept");
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule